// File: doc/BRIEF.md
# Interrupt Source Routing Unit

This block holds the complete state of a single interrupt source and decides which processor request lines it raises. It keeps a 32-bit control word and a destination-enable mask with one bit per CPU. It conditions the incoming request line and keeps a pending flag and an in-service (activity) flag. Whenever the source is eligible, it raises a one-cycle request toward the per-CPU arbiters.

There are two delivery modes. Directed delivery raises every enabled CPU at once. Distributed delivery raises exactly one CPU. It searches round-robin starting at the CPU after the last one served, wraps at the CPU count, and records the CPU it picked. The input can be level-sensitive or edge-sensitive, and it can be inverted. A single acknowledge pulse stands in for the downstream service flow.

Top module: `irq_src_router`

## Requirements
- R1: After reset, raise_o, pending_o, ctrl_o, dest_o and last_cpu_o are all zero.
- R2: A write with cfg_sel=0 loads ctrl_o from cfg_wdata, except bit 30 (activity), which keeps its hardware value. A write with cfg_sel=1 loads dest_o from cfg_wdata[NCPU-1:0]. Both take effect at the next clock edge.
- R3: With ctrl bit 22 (sense) at 1, the input is level-sensitive. pending_o takes the conditioned input level at each edge, and a low conditioned level clears activity.
- R4: With ctrl bit 22 at 0, the input is edge-sensitive. A low-to-high change of the conditioned input sets pending_o. pending_o then stays set after the input falls, until an ack_i pulse clears it.
- R5: With ctrl bit 23 (polarity) at 1, the raw input is inverted before edge or level detection.
- R6: Nothing is raised while any of these holds: pending is 0, ctrl bit 31 (mask) is 1, the priority field ctrl[20:16] is 0, or ctrl bit 30 (activity) is 1.
- R7: With ctrl bit 29 (mode) at 0, raise_o equals dest_o. It appears one cycle after pending is registered.
- R8: With ctrl bit 29 at 1, raise_o is one-hot. It selects the first enabled CPU after last_cpu_o, wrapping past NCPU-1 to 0, and last_cpu_o becomes that CPU.
- R9: When dest_o has only the bit of last_cpu_o set, the request goes to that CPU alone, in either mode.
- R10: A delivery sets ctrl bit 30. ack_i clears it, and while it is set no further request is raised.
- R11: raise_o is a single-cycle pulse. It never holds a nonzero value on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the destination mask |
| cfg_wdata | input | 32 | Write data |
| irq_in | input | 1 | Raw interrupt request line |
| ack_i | input | 1 | Service acknowledge: clears activity, and clears pending in edge mode |
| raise_o | output | NCPU | Request pulses to the per-CPU arbiters |
| pending_o | output | 1 | Pending flag |
| ctrl_o | output | 32 | Control word (mask 31, activity 30, mode 29, polarity 23, sense 22, priority 20:16) |
| dest_o | output | NCPU | Destination-enable mask |
| last_cpu_o | output | $clog2(NCPU) | Index of the last CPU served in distributed mode |

## Verification
A table of vectors sets the destination mask, the control word and the input levels. Each row then checks the exact cycle in which the raise appears. The rows separate directed fan-out to several CPUs, gating by mask, zero priority, an empty mask and an inactive input, and the two polarity settings under level sense. One edge-sensitive row is included. The directed follow-up tests walk distributed delivery through a rotation, wrap-around and the single-target case, checking last_cpu_o at each step. Further tests show that an edge-triggered pending flag survives the input falling and that activity blocks repeat raises until acknowledge. They also show that a low level clears activity and that software writes cannot clear activity.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Control word field positions; the delivery logic decodes these.
  localparam int unsigned CB_MASK   = 31;
  localparam int unsigned CB_ACT    = 30;
  localparam int unsigned CB_MODE   = 29;
  localparam int unsigned CB_POL    = 23;
  localparam int unsigned CB_SENSE  = 22;
  localparam int unsigned PRIO_LSB  = 16;
  localparam int unsigned PRIO_W    = 5;
  localparam int unsigned CTRL_W    = 32;

  typedef enum logic {
    DLV_DIRECTED    = 1'b0,
    DLV_DISTRIBUTED = 1'b1
  } dlv_mode_e;

  typedef enum logic {
    CFG_CTRL = 1'b0,
    CFG_DEST = 1'b1
  } cfg_sel_e;

  function automatic logic [PRIO_W-1:0] prio_of(input logic [CTRL_W-1:0] w);
    return w[PRIO_LSB +: PRIO_W];
  endfunction

endpackage

// File: rtl/irq_in_cond.sv
module irq_in_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic invert,
  input  logic level_mode,
  input  logic ack,
  output logic lvl,
  output logic pending
);

  logic lvl_q;
  logic rise;
  logic pend_q, pend_d;

  assign lvl  = irq_in ^ invert;
  assign rise = lvl & ~lvl_q;

  always_comb begin
    pend_d = pend_q;
    if (level_mode) begin
      pend_d = lvl;
    end else if (rise) begin
      pend_d = 1'b1;
    end else if (ack) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int unsigned NCPU = 4,
  localparam int unsigned LW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [NCPU-1:0] enables,
  input  logic [LW-1:0]   last,
  output logic [NCPU-1:0] pick,
  output logic [LW-1:0]   pick_idx,
  output logic            found
);

  always_comb begin
    pick     = '0;
    pick_idx = last;
    found    = 1'b0;
    for (int k = 1; k <= int'(NCPU); k++) begin
      int j;
      j = int'(last) + k;
      if (j >= int'(NCPU)) j = j - int'(NCPU);
      if (!found && enables[j]) begin
        pick[j]  = 1'b1;
        pick_idx = j[LW-1:0];
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel #(
  parameter int unsigned NCPU = 4,
  localparam int unsigned LW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [NCPU-1:0] dest,
  input  logic [LW-1:0]   last,
  input  logic            distributed,
  output logic [NCPU-1:0] targets,
  output logic [LW-1:0]   next_last
);

  logic [NCPU-1:0] rr_pick;
  logic [LW-1:0]   rr_idx;
  logic            rr_found;
  logic [NCPU-1:0] last_onehot;
  logic            only_last;

  irq_rr_pick #(.NCPU(NCPU)) u_rr (
    .enables (dest),
    .last    (last),
    .pick    (rr_pick),
    .pick_idx(rr_idx),
    .found   (rr_found)
  );

  assign last_onehot = {{(NCPU-1){1'b0}}, 1'b1} << last;
  assign only_last   = (dest == last_onehot);

  always_comb begin
    targets   = '0;
    next_last = last;
    if (only_last) begin
      targets = dest;
    end else if (!distributed) begin
      targets = dest;
    end else begin
      targets = rr_pick;
      if (rr_found) next_last = rr_idx;
    end
  end

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
  import irq_route_pkg::*;
#(
  parameter int unsigned NCPU = 4,
  localparam int unsigned LW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              irq_in,
  input  logic              ack_i,
  output logic [NCPU-1:0]   raise_o,
  output logic              pending_o,
  output logic [31:0]       ctrl_o,
  output logic [NCPU-1:0]   dest_o,
  output logic [LW-1:0]     last_cpu_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NCPU-1:0]   dest_q, dest_d;
  logic [LW-1:0]     last_q, last_d;
  logic [NCPU-1:0]   raise_q, raise_d;

  logic              lvl, pending;
  logic [NCPU-1:0]   targets;
  logic [LW-1:0]     next_last;
  logic              eligible, fire, act_d;
  logic              wr_ctrl, wr_dest;

  irq_in_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .irq_in    (irq_in),
    .invert    (ctrl_q[CB_POL]),
    .level_mode(ctrl_q[CB_SENSE]),
    .ack       (ack_i),
    .lvl       (lvl),
    .pending   (pending)
  );

  irq_target_sel #(.NCPU(NCPU)) u_sel (
    .dest       (dest_q),
    .last       (last_q),
    .distributed(ctrl_q[CB_MODE] == DLV_DISTRIBUTED),
    .targets    (targets),
    .next_last  (next_last)
  );

  assign wr_ctrl = cfg_we && (cfg_sel == CFG_CTRL);
  assign wr_dest = cfg_we && (cfg_sel == CFG_DEST);

  assign eligible = pending && !ctrl_q[CB_MASK] && !ctrl_q[CB_ACT] &&
                    (prio_of(ctrl_q) != '0);
  assign fire     = eligible && (|targets);

  always_comb begin
    act_d = ctrl_q[CB_ACT];
    if (fire) begin
      act_d = 1'b1;
    end else if (ack_i) begin
      act_d = 1'b0;
    end else if (ctrl_q[CB_SENSE] && !lvl) begin
      act_d = 1'b0;
    end
  end

  always_comb begin
    ctrl_d         = wr_ctrl ? cfg_wdata : ctrl_q;
    ctrl_d[CB_ACT] = act_d;
    dest_d         = wr_dest ? cfg_wdata[NCPU-1:0] : dest_q;
    raise_d        = fire ? targets : '0;
    last_d         = fire ? next_last : last_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= '0;
      dest_q  <= '0;
      last_q  <= '0;
      raise_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      dest_q  <= dest_d;
      last_q  <= last_d;
      raise_q <= raise_d;
    end
  end

  assign raise_o    = raise_q;
  assign pending_o  = pending;
  assign ctrl_o     = ctrl_q;
  assign dest_o     = dest_q;
  assign last_cpu_o = last_q;

endmodule

// File: rtl/irq_src_router_chk.sv
module irq_src_router_chk #(
  parameter int unsigned NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_in,
  input logic [NCPU-1:0] raise_o,
  input logic            pending_o,
  input logic [31:0]     ctrl_o,
  input logic [NCPU-1:0] dest_o
);

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_o) |-> ($past(pending_o) && !$past(ctrl_o[31]) &&
                    !$past(ctrl_o[30]) && ($past(ctrl_o[20:16]) != 5'd0)));

  assert_in_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_o & ~$past(dest_o)) == '0);

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_o[29]) |-> $onehot0(raise_o));

  assert_act_on_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_o) |-> ctrl_o[30]);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_o) |=> (raise_o == '0));

  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_o[22]) |-> (pending_o == $past(irq_in ^ ctrl_o[23])));

endmodule

bind irq_src_router irq_src_router_chk #(.NCPU(NCPU)) u_chk (.*);

// File: tb/sim_irq_src_router.sv
module sim_irq_src_router;

  localparam int NCPU = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we, cfg_sel, irq_in, ack_i;
  logic [31:0]     cfg_wdata;
  logic [NCPU-1:0] raise_o, dest_o;
  logic            pending_o;
  logic [31:0]     ctrl_o;
  logic [1:0]      last_cpu_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_src_router #(.NCPU(NCPU)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .irq_in(irq_in), .ack_i(ack_i),
    .raise_o(raise_o), .pending_o(pending_o), .ctrl_o(ctrl_o),
    .dest_o(dest_o), .last_cpu_o(last_cpu_o)
  );

  function automatic logic [31:0] mkv(bit m, bit mode, bit pol, bit sense,
                                      int prio, int vec);
    logic [31:0] w;
    w = '0;
    w[31] = m; w[29] = mode; w[23] = pol; w[22] = sense;
    w[20:16] = prio[4:0];
    w[7:0] = vec[7:0];
    return w;
  endfunction

  // Row: ctrl word, dest, idle level, drive level, expected raise
  localparam logic [41:0] ROWS [10] = '{
    {mkv(0,0,0,1,5,8'h11), 4'b1111, 1'b0, 1'b1, 4'b1111},
    {mkv(0,0,0,1,5,8'h12), 4'b0101, 1'b0, 1'b1, 4'b0101},
    {mkv(1,0,0,1,5,8'h13), 4'b1111, 1'b0, 1'b1, 4'b0000},
    {mkv(0,0,0,1,0,8'h14), 4'b1111, 1'b0, 1'b1, 4'b0000},
    {mkv(0,0,1,1,7,8'h15), 4'b0011, 1'b1, 1'b0, 4'b0011},
    {mkv(0,0,1,1,7,8'h16), 4'b0011, 1'b1, 1'b1, 4'b0000},
    {mkv(0,0,0,0,3,8'h17), 4'b1000, 1'b0, 1'b1, 4'b1000},
    {mkv(0,0,0,1,5,8'h18), 4'b0000, 1'b0, 1'b1, 4'b0000},
    {mkv(0,1,0,1,5,8'h19), 4'b0001, 1'b0, 1'b1, 4'b0001},
    {mkv(0,1,0,1,5,8'h1a), 4'b0110, 1'b0, 1'b1, 4'b0010}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // ack for one edge, then sample after the following edge
  task automatic ack_then_sample();
    @(negedge clk);
    ack_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ack_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    irq_in = 1'b0; ack_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 raise", 32'(raise_o), 0);
    chk("R1 pending", 32'(pending_o), 0);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 dest", 32'(dest_o), 0);
    chk("R1 last", 32'(last_cpu_o), 0);

    // Table walk: R5, R6, R7, R9 and edge row for R4
    for (int r = 0; r < 10; r++) begin
      logic [31:0] cw;
      logic [3:0]  dm, ex;
      logic        idl, drv;
      {cw, dm, idl, drv, ex} = ROWS[r];
      wr(1'b0, cw | 32'h8000_0000);
      wr(1'b1, 32'(dm));
      @(negedge clk);
      irq_in = idl;
      ack_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ack_i = 1'b0;
      wr(1'b0, cw);
      idle(1);
      chk($sformatf("R6 row%0d quiet before drive", r), 32'(raise_o), 0);
      irq_in = drv;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R7 row%0d raise", r), 32'(raise_o), 32'(ex));
      idle(1);
      chk($sformatf("R11 row%0d pulse", r), 32'(raise_o), 0);
    end
    chk("R8 last after row9", 32'(last_cpu_o), 1);

    // R8 distributed rotation with wrap (level held high, ack re-arms)
    wr(1'b1, 32'h9);
    ack_then_sample();
    chk("R8 pick after 1", 32'(raise_o), 32'h8);
    chk("R8 last=3", 32'(last_cpu_o), 3);
    ack_then_sample();
    chk("R8 wrap pick", 32'(raise_o), 32'h1);
    chk("R8 last=0", 32'(last_cpu_o), 0);
    wr(1'b1, 32'h2);
    ack_then_sample();
    chk("R8 lone other cpu", 32'(raise_o), 32'h2);
    chk("R8 last=1", 32'(last_cpu_o), 1);
    ack_then_sample();
    chk("R9 only last cpu", 32'(raise_o), 32'h2);
    chk("R9 last kept", 32'(last_cpu_o), 1);

    // R10 activity blocks repeats; R2 write keeps activity
    idle(3);
    chk("R10 no repeat while active", 32'(raise_o), 0);
    chk("R10 activity set", 32'(ctrl_o[30]), 1);
    wr(1'b0, mkv(0,1,0,1,6,8'h2b));
    chk("R2 ctrl write keeps activity", ctrl_o, mkv(0,1,0,1,6,8'h2b) | 32'h4000_0000);
    chk("R2 dest readback", 32'(dest_o), 32'h2);

    // R3 low level clears activity and pending
    @(negedge clk);
    irq_in = 1'b0;
    idle(1);
    chk("R3 activity cleared by low", 32'(ctrl_o[30]), 0);
    chk("R3 pending follows low", 32'(pending_o), 0);

    // R4 edge mode: pending survives the fall, ack clears it
    wr(1'b0, mkv(1,0,0,0,4,8'h30));
    wr(1'b1, 32'h4);
    wr(1'b0, mkv(0,0,0,0,4,8'h30));
    @(negedge clk);
    irq_in = 1'b1;
    @(negedge clk);
    irq_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R4 edge delivered", 32'(raise_o), 32'h4);
    idle(3);
    chk("R4 pending held after fall", 32'(pending_o), 1);
    chk("R10 quiet while active", 32'(raise_o), 0);
    @(negedge clk);
    ack_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ack_i = 1'b0;
    chk("R4 ack clears pending", 32'(pending_o), 0);
    chk("R10 ack clears activity", 32'(ctrl_o[30]), 0);
    idle(3);
    chk("R4 no raise after ack", 32'(raise_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule